// File: doc/BRIEF.md
# Dual-Channel Segmented Thermometer Switch Decoder

This block is the digital front end of a two-channel 8-bit current-steering converter. Each channel has its own clock and reset. On every rising edge a channel captures an 8-bit sample word. It splits the word into a 5-bit upper part and a 3-bit lower part and expands each part into unary control lines. The upper part drives 31 lines, each of full unit weight. The lower part drives 7 lines, each worth one eighth of an upper unit. Every line is delivered as a matched true/complement pair, ready to drive one differential current switch.

Decoding takes one register stage. A second register stage holds the switch drive, so every line of a channel changes on the same edge. The latency from input to switches is therefore fixed at two cycles. The two channels share nothing except a sleep input. While sleep is high, the block parks every switch so that all true lines are low and all complement lines are high.

Top module: `seg_dac_switch_decoder`

## Requirements
- R1: While a channel's active-low reset is asserted, all of its true lines are low and all of its complement lines are high, whatever the input code.
- R2: The upper segment is code bits [7:3]. Upper true line k (bit k of the `*_hi_p` bus, k = 0..30) is high exactly when the upper segment value is greater than k.
- R3: The lower segment is code bits [2:0]. Lower true line k (bit k of the `*_lo_p` bus, k = 0..6) is high exactly when the lower segment value is greater than k.
- R4: Every complement line (`*_hi_n`, `*_lo_n`) is at all times the exact inverse of the true line with the same index.
- R5: A code captured at rising edge N (with sleep low) appears on all lines of that channel after rising edge N+1. The count of high upper true lines times 8, plus the count of high lower true lines, equals the code.
- R6: If sleep is high at rising edge N, then after edge N+1 every true line of that channel is low and every complement line is high, whatever the code.
- R7: When sleep is released, the first code captured with sleep low is delivered after the following edge, with no further delay.
- R8: Each channel's outputs depend only on its own clock, reset and code. Codes and clocks on the other channel have no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Channel A sample clock |
| a_rst_n | input | 1 | Channel A asynchronous active-low reset |
| a_code | input | 8 | Channel A sample word |
| b_clk | input | 1 | Channel B sample clock |
| b_rst_n | input | 1 | Channel B asynchronous active-low reset |
| b_code | input | 8 | Channel B sample word |
| sleep | input | 1 | Park all switches (sampled in each channel's clock domain) |
| a_hi_p | output | 31 | Channel A upper-segment true lines |
| a_hi_n | output | 31 | Channel A upper-segment complement lines |
| a_lo_p | output | 7 | Channel A lower-segment true lines |
| a_lo_n | output | 7 | Channel A lower-segment complement lines |
| b_hi_p | output | 31 | Channel B upper-segment true lines |
| b_hi_n | output | 31 | Channel B upper-segment complement lines |
| b_lo_p | output | 7 | Channel B lower-segment true lines |
| b_lo_n | output | 7 | Channel B lower-segment complement lines |

## Verification
A code or sleep value is driven on a channel's falling edge. It is captured at the next rising edge, and its result is on the switches after the rising edge that follows. The bench therefore keeps a per-channel history and, at each falling edge, compares the outputs against the stimulus from two falling edges earlier. The other channel's outputs are checked after a sweep, to show they did not move. The reset state is checked while reset is still held. Sleep release is checked on the very first sample that follows it.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  // Number of unary lines needed for a segment of the given width.
  function automatic int unsigned seg_lines(input int unsigned seg_w);
    return (1 << seg_w) - 1;
  endfunction

  // Weight of a switch pattern in LSB units: each upper line counts
  // 2**lower_w units, each lower line counts one unit.
  function automatic int unsigned switch_weight(input int unsigned upper_cnt,
                                                input int unsigned lower_cnt,
                                                input int unsigned lower_w);
    return (upper_cnt << lower_w) + lower_cnt;
  endfunction

endpackage

// File: rtl/dsd_sample_reg.sv
module dsd_sample_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] code_in,
  input  logic              sleep_in,
  output logic [DATA_W-1:0] code_q,
  output logic              sleep_q,
  output logic              live_q
);

  // First stage: capture the word and the sleep request on the same edge.
  // live_q marks that code_q holds a captured sample, not a reset value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      sleep_q <= 1'b1;
      live_q  <= 1'b0;
    end else begin
      code_q  <= code_in;
      sleep_q <= sleep_in;
      live_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/dsd_thermo_decoder.sv
module dsd_thermo_decoder #(
  parameter int SEG_W = 5,
  localparam int LINES = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0] value,
  output logic [LINES-1:0] lines
);

  // Line k is high when the segment value exceeds k.
  for (genvar k = 0; k < LINES; k++) begin : g_line
    localparam logic [SEG_W-1:0] K_VAL = SEG_W'(k);
    assign lines[k] = (value > K_VAL);
  end

endmodule

// File: rtl/dsd_switch_reg.sv
module dsd_switch_reg #(
  parameter int LINES = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             park,
  input  logic [LINES-1:0] lines_in,
  output logic [LINES-1:0] sw_p,
  output logic [LINES-1:0] sw_n
);

  // True and complement halves are separate flops, so they present
  // matched drive to each differential switch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_p <= '0;
      sw_n <= '1;
    end else if (park) begin
      sw_p <= '0;
      sw_n <= '1;
    end else begin
      sw_p <= lines_in;
      sw_n <= ~lines_in;
    end
  end

  AST_COMP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_n == ~sw_p)); // R4

  AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> (sw_p == '0 && sw_n == '1)); // R6

endmodule

// File: rtl/dsd_channel.sv
module dsd_channel #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 5,
  localparam int LO_W    = DATA_W - HI_W,
  localparam int HI_LINES = (1 << HI_W) - 1,
  localparam int LO_LINES = (1 << LO_W) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   code,
  input  logic                sleep,
  output logic [HI_LINES-1:0] hi_p,
  output logic [HI_LINES-1:0] hi_n,
  output logic [LO_LINES-1:0] lo_p,
  output logic [LO_LINES-1:0] lo_n
);
  import dsd_pkg::*;

  logic [DATA_W-1:0]   code_s1;
  logic                sleep_s1;
  logic                live_s1;
  logic [HI_LINES-1:0] hi_dec;
  logic [LO_LINES-1:0] lo_dec;

  dsd_sample_reg #(.DATA_W(DATA_W)) u_sample (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_in  (code),
    .sleep_in (sleep),
    .code_q   (code_s1),
    .sleep_q  (sleep_s1),
    .live_q   (live_s1)
  );

  dsd_thermo_decoder #(.SEG_W(HI_W)) u_hi_dec (
    .value (code_s1[DATA_W-1:LO_W]),
    .lines (hi_dec)
  );

  dsd_thermo_decoder #(.SEG_W(LO_W)) u_lo_dec (
    .value (code_s1[LO_W-1:0]),
    .lines (lo_dec)
  );

  dsd_switch_reg #(.LINES(HI_LINES)) u_hi_sw (
    .clk      (clk),
    .rst_n    (rst_n),
    .park     (sleep_s1),
    .lines_in (hi_dec),
    .sw_p     (hi_p),
    .sw_n     (hi_n)
  );

  dsd_switch_reg #(.LINES(LO_LINES)) u_lo_sw (
    .clk      (clk),
    .rst_n    (rst_n),
    .park     (sleep_s1),
    .lines_in (lo_dec),
    .sw_p     (lo_p),
    .sw_n     (lo_n)
  );

  // Named observation wires for the assertions.
  logic [DATA_W:0] sw_weight;
  logic            hi_is_thermo;
  logic            lo_is_thermo;

  assign sw_weight    = (DATA_W+1)'(switch_weight($countones(hi_p), $countones(lo_p), LO_W));
  assign hi_is_thermo = ((hi_p & (hi_p + 1'b1)) == '0);
  assign lo_is_thermo = ((lo_p & (lo_p + 1'b1)) == '0);

  AST_HI_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_is_thermo); // R2

  AST_LO_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    lo_is_thermo); // R3

  AST_CODE_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (live_s1 && !sleep_s1) |=> (sw_weight == {1'b0, $past(code_s1)})); // R5

  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleep_s1) && live_s1) |=> (sw_weight == {1'b0, $past(code_s1)})); // R7

endmodule

// File: rtl/seg_dac_switch_decoder.sv
module seg_dac_switch_decoder #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 5,
  localparam int LO_W     = DATA_W - HI_W,
  localparam int HI_LINES = (1 << HI_W) - 1,
  localparam int LO_LINES = (1 << LO_W) - 1,
  localparam int N_CH     = 2
) (
  input  logic                a_clk,
  input  logic                a_rst_n,
  input  logic [DATA_W-1:0]   a_code,
  input  logic                b_clk,
  input  logic                b_rst_n,
  input  logic [DATA_W-1:0]   b_code,
  input  logic                sleep,
  output logic [HI_LINES-1:0] a_hi_p,
  output logic [HI_LINES-1:0] a_hi_n,
  output logic [LO_LINES-1:0] a_lo_p,
  output logic [LO_LINES-1:0] a_lo_n,
  output logic [HI_LINES-1:0] b_hi_p,
  output logic [HI_LINES-1:0] b_hi_n,
  output logic [LO_LINES-1:0] b_lo_p,
  output logic [LO_LINES-1:0] b_lo_n
);

  logic [N_CH-1:0]     clk_v;
  logic [N_CH-1:0]     rst_v;
  logic [DATA_W-1:0]   code_v [N_CH];
  logic [HI_LINES-1:0] hi_p_v [N_CH];
  logic [HI_LINES-1:0] hi_n_v [N_CH];
  logic [LO_LINES-1:0] lo_p_v [N_CH];
  logic [LO_LINES-1:0] lo_n_v [N_CH];

  assign clk_v     = {b_clk, a_clk};
  assign rst_v     = {b_rst_n, a_rst_n};
  assign code_v[0] = a_code;
  assign code_v[1] = b_code;

  // Identical, fully separate channels; only sleep is shared.
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dsd_channel #(.DATA_W(DATA_W), .HI_W(HI_W)) u_ch (
      .clk   (clk_v[c]),
      .rst_n (rst_v[c]),
      .code  (code_v[c]),
      .sleep (sleep),
      .hi_p  (hi_p_v[c]),
      .hi_n  (hi_n_v[c]),
      .lo_p  (lo_p_v[c]),
      .lo_n  (lo_n_v[c])
    );
  end

  assign a_hi_p = hi_p_v[0];
  assign a_hi_n = hi_n_v[0];
  assign a_lo_p = lo_p_v[0];
  assign a_lo_n = lo_n_v[0];
  assign b_hi_p = hi_p_v[1];
  assign b_hi_n = hi_n_v[1];
  assign b_lo_p = lo_p_v[1];
  assign b_lo_n = lo_n_v[1];

endmodule

// File: tb/seg_dac_switch_decoder_test.sv
`timescale 1ns/1ps
module seg_dac_switch_decoder_test;

  logic       a_clk = 1'b0, b_clk = 1'b0;
  logic       a_rst_n = 1'b0, b_rst_n = 1'b0;
  logic [7:0] a_code = 8'hFF, b_code = 8'hFF;
  logic       sleep = 1'b0;
  logic [30:0] a_hi_p, a_hi_n, b_hi_p, b_hi_n;
  logic [6:0]  a_lo_p, a_lo_n, b_lo_p, b_lo_n;

  int checks = 0;
  int failures = 0;

  logic [7:0] hcode [2][600];
  logic       hslp  [2][600];
  int         nst   [2];

  seg_dac_switch_decoder uut (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_code(a_code),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_code(b_code),
    .sleep(sleep),
    .a_hi_p(a_hi_p), .a_hi_n(a_hi_n), .a_lo_p(a_lo_p), .a_lo_n(a_lo_n),
    .b_hi_p(b_hi_p), .b_hi_n(b_hi_n), .b_lo_p(b_lo_p), .b_lo_n(b_lo_n)
  );

  always #2.5 a_clk = ~a_clk;
  initial begin
    #1;
    forever #2.5 b_clk = ~b_clk;
  end

  // Expected pattern: the low 'n' lines are high.
  function automatic logic [30:0] exp_lines(input int n);
    return 31'((64'd1 << n) - 64'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_ch(input int ch, input logic [7:0] code,
                          input logic slp, input string wtag);
    logic [30:0] hp, hn;
    logic [6:0]  lp, ln;
    logic [30:0] ehi;
    logic [6:0]  elo;
    int weight;
    if (ch == 0) begin hp = a_hi_p; hn = a_hi_n; lp = a_lo_p; ln = a_lo_n; end
    else         begin hp = b_hi_p; hn = b_hi_n; lp = b_lo_p; ln = b_lo_n; end
    ehi = slp ? '0 : exp_lines(int'(code[7:3]));
    elo = slp ? '0 : 7'(exp_lines(int'(code[2:0])));
    weight = $countones(hp) * 8 + $countones(lp);
    chk(hp == ehi, slp ? "R6" : "R2", "upper true lines", hp, ehi);
    chk(lp == elo, slp ? "R6" : "R3", "lower true lines", lp, elo);
    chk(hn == ~hp && ln == ~lp, "R4", "complement lines", {hn, ln}, {~hp, ~lp});
    chk(weight == (slp ? 0 : int'(code)), wtag, "switch weight", weight, slp ? 0 : code);
  endtask

  // One falling-edge step: check the result of the step two edges back,
  // then drive this step's code and sleep.
  task automatic step(input int ch, input logic [7:0] code, input logic slp);
    int i;
    string tag;
    if (ch == 0) @(negedge a_clk); else @(negedge b_clk);
    i = nst[ch];
    if (i >= 2) begin
      if (hslp[ch][i-2]) tag = "R6";
      else if (i >= 3 && hslp[ch][i-3]) tag = "R7";
      else tag = "R5";
      check_ch(ch, hcode[ch][i-2], hslp[ch][i-2], tag);
    end
    if (ch == 0) a_code = code; else b_code = code;
    sleep = slp;
    hcode[ch][i] = code;
    hslp[ch][i]  = slp;
    nst[ch] = i + 1;
  endtask

  task automatic sweep(input int ch);
    nst[ch] = 0;
    for (int c = 0; c < 256; c++) step(ch, 8'(c), 1'b0);
    // directed: sleep with full scale, release straight into full scale
    step(ch, 8'hFF, 1'b1);
    step(ch, 8'hFF, 1'b1);
    step(ch, 8'hFF, 1'b0);
    step(ch, 8'h00, 1'b0);
    step(ch, 8'h08, 1'b1);
    step(ch, 8'h07, 1'b0);
    step(ch, 8'hF8, 1'b0);
    for (int r = 0; r < 90; r++)
      step(ch, 8'($urandom_range(0, 255)), ($urandom_range(0, 3) == 0));
    step(ch, 8'h5A, 1'b0);
    step(ch, 8'h5A, 1'b0);
    step(ch, 8'h5A, 1'b0);
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED);
    repeat (4) @(negedge a_clk);
    // R1: reset state with full-scale codes and clocks running
    chk(a_hi_p == '0 && a_lo_p == '0, "R1", "A true lines in reset", {a_hi_p, a_lo_p}, 0);
    chk(a_hi_n == '1 && a_lo_n == '1, "R1", "A comp lines in reset", {a_hi_n, a_lo_n}, 38'h3FFFFFFFFF);
    chk(b_hi_p == '0 && b_lo_p == '0, "R1", "B true lines in reset", {b_hi_p, b_lo_p}, 0);
    chk(b_hi_n == '1 && b_lo_n == '1, "R1", "B comp lines in reset", {b_hi_n, b_lo_n}, 38'h3FFFFFFFFF);
    b_code = 8'hA5;
    a_rst_n = 1'b1;
    @(negedge b_clk);
    b_rst_n = 1'b1;
    repeat (3) @(negedge b_clk);
    check_ch(1, 8'hA5, 1'b0, "R5");

    sweep(0);
    // R8: channel B untouched by channel A activity (sleep now low)
    repeat (3) @(negedge b_clk);
    check_ch(1, 8'hA5, 1'b0, "R8");

    a_code = 8'h3C;
    repeat (3) @(negedge a_clk);
    sweep(1);
    // R8: channel A untouched by channel B activity
    repeat (3) @(negedge a_clk);
    check_ch(0, 8'h3C, 1'b0, "R8");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule